// File: doc/BRIEF.md
# Pulse Record Receive Queue

This block is a synchronous first-in first-out queue of 32 words by 32 bits that sits between an infrared pulse-width capture stage and a processor. The capture stage pushes one record per measured level; the processor pops records at its own pace. The current head record is always visible on the read data port, and a pop takes effect at the clock edge on which the read strobe is high.

When a record arrives while the queue already holds 32 words, a policy input decides the outcome: either the oldest stored record is thrown away so the newest survives, or the incoming record is refused and the stored ones are kept. Four sticky status bits report overflow, an upward crossing of a programmable fill threshold, the queue becoming full, and a read attempted while empty. Each bit has its own enable (which gates setting), mask (which gates the interrupt line) and write-1-to-clear strobe. A flush strobe empties the queue in one cycle.

Top module: `pulse_rec_fifo`

## Requirements
- R1: While and after synchronous reset (rst high), level is 0, empty is 1, full is 0, irq_status is 0, irq is 0 and rd_data is 0.
- R2: Records leave in the order they were written; level counts the stored records from 0 to 32, empty is 1 exactly at level 0 and full is 1 exactly at level 32. A write and a read in the same cycle on a non-empty queue leave level unchanged.
- R3: A read while empty presents rd_data = 0, leaves the contents and level unchanged, and sets status bit 3 (read error) when irq_en[3] is 1.
- R4: With drop_new = 0, a write while full and without a read drops the oldest record and stores the new one; level stays 32.
- R5: With drop_new = 1, a write while full and without a read is refused; level stays 32 and the stored records are unchanged.
- R6: Status bit 0 (overflow) is set by a write while full without a read in the same cycle, under either policy; a write with a simultaneous read on a full queue does not set it.
- R7: Status bit 1 (level) is set only when level goes from lvl_thresh to lvl_thresh + 1; falling or holding level does not set it.
- R8: Status bit 2 (full) is set when level changes to 32 from a lower value; a write that keeps level at 32 does not set it.
- R9: A status bit is set only when its irq_en bit is 1; irq is the OR of status bits whose irq_mask bit is 0.
- R10: Status bits stay set until a 1 on the matching irq_clr bit; if an event and a clear hit the same bit in one cycle, the bit ends set.
- R11: flush empties the queue in one cycle (level 0 on the next cycle); writes and reads in that cycle are ignored and raise no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 32 | Record to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 32 | Head record, 0 when empty |
| flush | input | 1 | Empty the queue |
| drop_new | input | 1 | Full policy: 0 drop oldest, 1 refuse new |
| lvl_thresh | input | 5 | Fill threshold for the level event |
| irq_en | input | 4 | Per-bit status enable (bit0 ovf, bit1 level, bit2 full, bit3 read error) |
| irq_mask | input | 4 | Per-bit interrupt mask, 1 masks |
| irq_clr | input | 4 | Per-bit write-1-to-clear |
| level | output | 6 | Stored record count 0..32 |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| irq_status | output | 4 | Sticky status bits |
| irq | output | 1 | Interrupt line |

## Verification
The bench pushes a 33rd record under each policy and then drains the whole queue, so a design that dropped the wrong end, advanced the wrong pointer or let a refused record through shows up as a wrong value at a specific position. It reads an empty queue and then writes and reads again, catching a design that moves its read pointer on an empty read. It walks the fill level through the threshold and across 32 in both directions, so a level or full event raised on a falling, holding or wrapping count is seen, and it collides a clear with an event and a write with a read on a full queue to expose wrong priorities.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned REC_W_DEF = 32;
    localparam int unsigned DEPTH_DEF = 32;

    localparam int unsigned N_EV     = 4;
    localparam int unsigned EV_OVF   = 0;
    localparam int unsigned EV_LVL   = 1;
    localparam int unsigned EV_FULL  = 2;
    localparam int unsigned EV_RDERR = 3;

    typedef logic [N_EV-1:0] ev_vec_t;

    typedef struct packed {
        logic push;
        logic pop;
    } ptr_op_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             flush,
    input  logic             drop_new,
    input  logic [PTR_W-1:0] thr,
    output ptr_op_t          op,
    output logic [CNT_W-1:0] cnt_nxt,
    output ev_vec_t          ev
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic is_empty, is_full, rd_ok, wr_room, drop_head;
    logic [CNT_W-1:0] thr_ext;

    always_comb begin
        is_empty  = (cnt == '0);
        is_full   = (cnt == FULL_CNT);
        rd_ok     = rd_en && !is_empty && !flush;
        wr_room   = !is_full || rd_ok;
        drop_head = wr_en && !flush && !wr_room && !drop_new;
        op.push   = wr_en && !flush && (wr_room || !drop_new);
        op.pop    = rd_ok || drop_head;
        if (flush)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CNT_W'(op.push) - CNT_W'(op.pop);
        thr_ext         = CNT_W'(thr);
        ev[EV_OVF]      = wr_en && !flush && !wr_room;
        ev[EV_LVL]      = !flush && (cnt == thr_ext) && (cnt_nxt == thr_ext + ONE);
        ev[EV_FULL]     = !flush && !is_full && (cnt_nxt == FULL_CNT);
        ev[EV_RDERR]    = rd_en && !flush && is_empty;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned WIDTH = REC_W_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  ptr_op_t          op,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [WIDTH-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [WIDTH-1:0] head
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (op.push) wr_ptr <= bump(wr_ptr);
            if (op.pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst && op.push) mem[wr_ptr] <= wr_data;
    end

    assign head = (cnt == '0) ? '0 : mem[rd_ptr];
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t ev,
    input  ev_vec_t en,
    input  ev_vec_t mask,
    input  ev_vec_t clr,
    output ev_vec_t status,
    output logic    irq
);
    for (genvar i = 0; i < N_EV; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (ev[i] && en[i])
                status[i] <= 1'b1;
            else if (clr[i])
                status[i] <= 1'b0;
        end
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/pulse_rec_fifo.sv
module pulse_rec_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned WIDTH = REC_W_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             flush,
    input  logic             drop_new,
    input  logic [PTR_W-1:0] lvl_thresh,
    input  logic [N_EV-1:0]  irq_en,
    input  logic [N_EV-1:0]  irq_mask,
    input  logic [N_EV-1:0]  irq_clr,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic [N_EV-1:0]  irq_status,
    output logic             irq
);
    ptr_op_t          op;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    ev_vec_t          ev;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .cnt(cnt), .wr_en(wr_en), .rd_en(rd_en), .flush(flush),
        .drop_new(drop_new), .thr(lvl_thresh),
        .op(op), .cnt_nxt(cnt_nxt), .ev(ev)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .op(op), .cnt_nxt(cnt_nxt),
        .wr_data(wr_data), .cnt(cnt), .head(rd_data)
    );

    rxq_irq u_irq (
        .clk(clk), .rst(rst), .ev(ev), .en(irq_en), .mask(irq_mask),
        .clr(irq_clr), .status(irq_status), .irq(irq)
    );

    assign level = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             flush,
    input logic             drop_new,
    input logic             en_rderr,
    input logic             clr_ovf,
    input logic [CNT_W-1:0] level,
    input logic             empty,
    input logic             full,
    input logic [3:0]       irq_status
);
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    a_r2_level_step: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (level == $past(level)) || (level == $past(level) + CNT_W'(1))
                   || (level + CNT_W'(1) == $past(level)));

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0) && empty);

    a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !flush && full && !drop_new) |=> full);

    a_r5_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !flush && full && drop_new) |=> full && $stable(level));

    a_r3_rderr_sets: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !flush && en_rderr) |=> irq_status[3]);

    a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
        (irq_status[0] && !clr_ovf) |=> irq_status[0]);
endmodule

bind pulse_rec_fifo rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .flush(flush),
    .drop_new(drop_new), .en_rderr(irq_en[3]), .clr_ovf(irq_clr[0]),
    .level(level), .empty(empty), .full(full), .irq_status(irq_status)
);

// File: tb/tb_pulse_rec_fifo.sv
module tb_pulse_rec_fifo;
    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en, flush, drop_new;
    logic [31:0] wr_data, rd_data;
    logic [4:0]  lvl_thresh;
    logic [3:0]  irq_en, irq_mask, irq_clr, irq_status;
    logic [5:0]  level;
    logic        empty, full, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pulse_rec_fifo dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .flush(flush), .drop_new(drop_new),
        .lvl_thresh(lvl_thresh), .irq_en(irq_en), .irq_mask(irq_mask),
        .irq_clr(irq_clr), .level(level), .empty(empty), .full(full),
        .irq_status(irq_status), .irq(irq)
    );

    // vector: op[23:22] (1 write, 2 read, 3 both), wdata[21:14], exp_rd[13:6], exp_level[5:0]
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 8'h01, 8'h00, 6'd1},
        {2'd1, 8'h02, 8'h00, 6'd2},
        {2'd1, 8'h03, 8'h00, 6'd3},
        {2'd2, 8'h00, 8'h01, 6'd2},
        {2'd3, 8'h04, 8'h02, 6'd2},
        {2'd2, 8'h00, 8'h03, 6'd1},
        {2'd2, 8'h00, 8'h04, 6'd0},
        {2'd2, 8'h00, 8'h00, 6'd0},
        {2'd1, 8'h05, 8'h00, 6'd1},
        {2'd2, 8'h00, 8'h05, 6'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop_exp(input string tag, input logic [31:0] exp);
        rd_en = 1'b1;
        chk(tag, rd_data, exp);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic clear(input logic [3:0] m);
        irq_clr = m;
        tick();
        irq_clr = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; flush = 0; drop_new = 0;
        wr_data = '0; lvl_thresh = '0; irq_en = '0; irq_mask = '0; irq_clr = '0;
        repeat (3) tick();
        chk("R1 level", 32'(level), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 status", 32'(irq_status), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rd_data", rd_data, 0);
        rst = 1'b0;
        tick();

        // table walk, all enables off
        for (int i = 0; i < NV; i++) begin
            wr_en   = VEC[i][22];
            rd_en   = VEC[i][23];
            wr_data = {24'h0, VEC[i][21:14]};
            if (VEC[i][23]) chk($sformatf("R2 vec%0d rd_data", i), rd_data, {24'h0, VEC[i][13:6]});
            tick();
            chk($sformatf("R2 vec%0d level", i), 32'(level), 32'(VEC[i][5:0]));
            wr_en = 0; rd_en = 0;
        end
        chk("R9 no status while disabled", 32'(irq_status), 0);
        chk("R2 empty at end", 32'(empty), 1);

        // read error
        irq_en = 4'hF;
        pop_exp("R3 empty rd_data", 0);
        chk("R3 level unchanged", 32'(level), 0);
        chk("R3 error status", 32'(irq_status), 32'h8);
        chk("R9 irq unmasked", 32'(irq), 1);
        clear(4'h8);
        chk("R10 cleared", 32'(irq_status), 0);
        chk("R10 irq low", 32'(irq), 0);

        // threshold crossing and full
        lvl_thresh = 5'd3;
        for (int i = 0; i < 32; i++) begin
            push(32'd100 + 32'(i));
            if (i == 2) chk("R7 no level at 3", 32'(irq_status[1]), 0);
            if (i == 3) chk("R7 level at 4", 32'(irq_status[1]), 1);
            if (i == 30) chk("R8 not full at 31", 32'(irq_status[2]), 0);
        end
        chk("R2 full flag", 32'(full), 1);
        chk("R8 full status", 32'(irq_status), 32'h6);
        irq_mask = 4'hF;
        tick();
        chk("R9 masked irq", 32'(irq), 0);
        irq_mask = 4'h0;
        tick();
        chk("R9 unmasked irq", 32'(irq), 1);
        clear(4'hF);

        // drop oldest
        drop_new = 1'b0;
        push(32'd200);
        chk("R4 level stays 32", 32'(level), 32);
        chk("R6 R8 ovf only", 32'(irq_status), 32'h1);
        for (int i = 1; i < 32; i++) pop_exp($sformatf("R4 order %0d", i), 32'd100 + 32'(i));
        pop_exp("R4 new last", 32'd200);
        chk("R7 no level on fall", 32'(irq_status[1]), 0);
        chk("R2 empty after drain", 32'(empty), 1);

        // reject new
        clear(4'hF);
        for (int i = 0; i < 32; i++) push(32'd300 + 32'(i));
        clear(4'hF);
        drop_new = 1'b1;
        push(32'd999);
        chk("R5 level stays 32", 32'(level), 32);
        chk("R6 ovf on reject", 32'(irq_status), 32'h1);
        for (int i = 0; i < 32; i++) pop_exp($sformatf("R5 order %0d", i), 32'd300 + 32'(i));
        drop_new = 1'b0;

        // write with read on full queue
        for (int i = 0; i < 32; i++) push(32'd400 + 32'(i));
        clear(4'hF);
        wr_en = 1'b1; wr_data = 32'd500;
        pop_exp("R6 head on simultaneous", 32'd400);
        wr_en = 1'b0;
        chk("R2 level on simultaneous", 32'(level), 32);
        chk("R6 no ovf with read", 32'(irq_status), 0);

        // flush
        flush = 1'b1; wr_en = 1'b1; wr_data = 32'h77;
        tick();
        flush = 1'b0; wr_en = 1'b0;
        chk("R11 level 0", 32'(level), 0);
        chk("R11 empty", 32'(empty), 1);
        chk("R11 rd_data 0", rd_data, 0);
        chk("R11 no status", 32'(irq_status), 0);
        push(32'h88);
        pop_exp("R11 after flush", 32'h88);

        // set beats clear
        rd_en = 1'b1; irq_clr = 4'h8;
        tick();
        rd_en = 1'b0; irq_clr = 4'h0;
        chk("R10 set wins", 32'(irq_status[3]), 1);

        // reset mid-run
        push(32'h55);
        rst = 1'b1;
        tick();
        chk("R1 level after rst", 32'(level), 0);
        chk("R1 status after rst", 32'(irq_status), 0);
        chk("R1 irq after rst", 32'(irq), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule